// File: doc/BRIEF.md
# Text-Mode VGA Character Renderer

The renderer produces 640x480 VGA timing from a 50 MHz clock and draws an 80-column by 30-row text screen with 8x16 glyphs. For every character cell it reads three bytes from an external SRAM: the character code, an attribute byte and a color byte. It then forms an address into an external glyph ROM, fetches one glyph row, and shifts that row out as pixels. Each pixel is drawn in one of 16 colors on a six-pin weighted output.

Memory reads take time, so a fetch and its display are two cells apart. The visible window, and with it horizontal blanking and sync, therefore starts two character cells later than an unshifted line. The attribute byte selects a font, enables an underline and enables blinking of the foreground or the background. The underline scanline comes from a 2-bit input.

The vertical geometry and the blink rate are parameters. The horizontal geometry is given in character cells. The defaults produce the standard 640x480 frame.

Top module: `vga_text_renderer`

## Requirements
- R1: The pixel counter advances once per clock and wraps after 1600 clocks, where it advances the line counter. The line counter wraps after V_VIS+V_FP+V_SYNC+V_BP lines (525 by default). The line period is therefore 1600 clocks, and the frame period is that line count times 1600.
- R2: `hsync_n` is low for 192 clocks in each line, from clock 1344 to clock 1535 of the line (cells 84 to 95). It is high for the rest of the line.
- R3: `vsync_n` is low for V_SYNC lines, starting at line V_VIS+V_FP. It is high for all other lines.
- R4: `pix_out` is 0 outside the visible window. The window covers line clocks 32 to 1311 (cells 2 to 81) of lines 0 to V_VIS-1.
- R5: `ram_addr` is {page[1:0], text row = line[8:4], cell = clock[10:4]}. The page is 0 (code) in cell phases 0-3, 1 (attribute) in phases 4-7 and 2 (color) in phases 8-15, where the phase is clock[3:0]. The external memories return data two clocks after an address is presented.
- R6: During cell phases 8-15, `rom_addr` is {attribute[7:3], code[7:0], line[3:0]}. The code and attribute are the ones stored for the cell being fetched.
- R7: The cell fetched in cell c is shown during cell c+2. Each pixel lasts two clocks. Glyph bit 7 is the leftmost pixel, so clock[3:1] = p shows glyph bit 7-p.
- R8: A pixel whose glyph bit is set uses the color byte's high nibble as its color index. A pixel whose bit is clear uses the low nibble.
- R9: For color index i, pins 2:0 are {R,G,B} = i[2:0] at 2/3 weight, and pins 5:3 are all equal to i[3] at 1/3 weight. Index 6 is the exception and is driven as 6'b010_100 (brown).
- R10: When attribute bit 2 is set, every pixel of the cell on scanline 15-`ul_sel` uses the foreground color.
- R11: A frame counter toggles its bit BLINK_BIT once per frame period chain. While that bit is 1, attribute bit 0 turns every foreground pixel into background, and attribute bit 1 replaces the background index with 0.
- R12: While `rst_n` is low, all counters and fetch registers are zero. In that state `pix_out` is 0, both syncs are high, `ram_addr` is 0 and `rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ul_sel | input | 2 | Underline scanline select (15 minus value) |
| ram_addr | output | 14 | SRAM read address |
| ram_data | input | 8 | SRAM read data |
| rom_addr | output | 17 | Glyph ROM read address |
| rom_data | input | 8 | Glyph ROM read data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pix_out | output | 6 | {1/3-weight RGB, 2/3-weight RGB} |

## Verification
The memories are filled with hashed codes, attributes and colors. As a result, neighbouring cells differ in font, underline and blink bits, and in both color nibbles. Every visible pixel is compared against a model built from the requirements. This exposes a wrong pipeline offset, a wrong bit order and swapped color nibbles. The underline select is stepped through all four values across frames, and the blink phase alternates every frame. Together these separate underline rows, blink masking and the brown correction from plain colors.

// File: rtl/vga_text_renderer.sv
module vga_text_renderer #(
  parameter int H_VIS     = 80,
  parameter int H_FP      = 2,
  parameter int H_SYNC    = 12,
  parameter int H_BP      = 6,
  parameter int SHIFT     = 2,
  parameter int V_VIS     = 480,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int BLINK_BIT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ul_sel,
  output logic [13:0] ram_addr,
  input  logic [7:0]  ram_data,
  output logic [16:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [5:0]  pix_out
);

  localparam int H_TOTAL = (H_VIS + H_FP + H_SYNC + H_BP) * 16;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = SHIFT + H_VIS + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_VIS + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic [10:0]        hcnt;
  logic [9:0]         vcnt;
  logic [BLINK_BIT:0] fcnt;

  wire [3:0] phase    = hcnt[3:0];
  wire [6:0] hcol     = hcnt[10:4];
  wire [3:0] scan     = vcnt[3:0];
  wire [4:0] trow     = vcnt[8:4];
  wire       line_end = (hcnt == 11'(H_TOTAL - 1));
  wire       last_ln  = (vcnt == 10'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      fcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      if (last_ln) begin
        vcnt <= '0;
        fcnt <= fcnt + 1'b1;
      end else begin
        vcnt <= vcnt + 10'd1;
      end
    end else begin
      hcnt <= hcnt + 11'd1;
    end
  end

  logic [1:0] page;
  always_comb begin
    if (phase < 4'd4)      page = 2'd0;
    else if (phase < 4'd8) page = 2'd1;
    else                   page = 2'd2;
  end
  assign ram_addr = {page, trow, hcol};

  logic [7:0] code_r, attr_r, colr_r;
  logic [7:0] pend_glyph, pend_attr, pend_col;
  logic [7:0] disp_glyph, disp_attr, disp_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_r     <= '0;
      attr_r     <= '0;
      colr_r     <= '0;
      pend_glyph <= '0;
      pend_attr  <= '0;
      pend_col   <= '0;
      disp_glyph <= '0;
      disp_attr  <= '0;
      disp_col   <= '0;
    end else begin
      case (phase)
        4'd3:  code_r <= ram_data;
        4'd7:  attr_r <= ram_data;
        4'd11: colr_r <= ram_data;
        4'd15: begin
          pend_glyph <= rom_data;
          pend_attr  <= attr_r;
          pend_col   <= colr_r;
          disp_glyph <= pend_glyph;
          disp_attr  <= pend_attr;
          disp_col   <= pend_col;
        end
        default: ;
      endcase
    end
  end

  assign rom_addr = {attr_r[7:3], code_r, scan};

  wire       hvis    = (hcol >= 7'(SHIFT)) && (hcol < 7'(SHIFT + H_VIS));
  wire       vvis    = (vcnt < 10'(V_VIS));
  wire       blink   = fcnt[BLINK_BIT];
  wire       gbit    = disp_glyph[3'd7 - hcnt[3:1]];
  wire [3:0] ul_row  = 4'd15 - {2'b00, ul_sel};
  wire       fg_on   = (gbit | (disp_attr[2] & (scan == ul_row))) & ~(blink & disp_attr[0]);
  wire [3:0] bg_idx  = (blink & disp_attr[1]) ? 4'd0 : disp_col[3:0];
  wire [3:0] idx     = fg_on ? disp_col[7:4] : bg_idx;
  wire [5:0] rgb     = (idx == 4'd6) ? 6'b010_100 : {{3{idx[3]}}, idx[2:0]};

  assign pix_out = (hvis && vvis) ? rgb : 6'd0;
  assign hsync_n = !((hcol >= 7'(HS_BEG)) && (hcol < 7'(HS_END)));
  assign vsync_n = !((vcnt >= 10'(VS_BEG)) && (vcnt < 10'(VS_END)));

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < 11'(H_TOTAL)); // R1
  AST_LINE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == 11'd0) && ((vcnt == 10'd0) || (vcnt == $past(vcnt) + 10'd1))); // R1
  AST_HSYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> (pix_out == 6'd0)); // R4
  AST_VSYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (pix_out == 6'd0)); // R4
  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase > 4'd8) |-> $stable(rom_addr)); // R6

endmodule

// File: tb/tb_vga_text_renderer.sv
module tb_vga_text_renderer;
  localparam int CLK_PERIOD = 20;
  localparam int VV  = 18;
  localparam int VFP = 1;
  localparam int VS  = 1;
  localparam int VBP = 1;
  localparam int BB  = 0;
  localparam int HT  = 1600;
  localparam int VT  = VV + VFP + VS + VBP;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ul_sel = 0;
  logic [13:0] ram_addr;
  logic [7:0]  ram_data, rd1;
  logic [16:0] rom_addr;
  logic [7:0]  rom_data, od1;
  logic        hsync_n, vsync_n;
  logic [5:0]  pix_out;

  vga_text_renderer #(.V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .BLINK_BIT(BB)) dut (
    .clk(clk), .rst_n(rst_n), .ul_sel(ul_sel),
    .ram_addr(ram_addr), .ram_data(ram_data),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_out(pix_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ram_fn(input logic [13:0] a);
    int v = int'(a);
    case (a[13:12])
      2'd0:    return 8'((v * 7) + (v >> 5));
      2'd1:    return 8'((v * 37) + (v >> 3) + 5);
      2'd2:    return 8'((v * 29) + (v >> 7) + 1);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rom_fn(input logic [16:0] a);
    int v = int'(a);
    return 8'((v * 113) ^ (v >> 6));
  endfunction

  always @(posedge clk) begin
    rd1 <= ram_fn(ram_addr);
    ram_data <= rd1;
    od1 <= rom_fn(rom_addr);
    rom_data <= od1;
  end

  function automatic logic [5:0] pal(input logic [3:0] i);
    if (i == 4'd6) return 6'b010_100;
    return {{3{i[3]}}, i[2:0]};
  endfunction

  typedef struct {
    logic [5:0]  pix;
    logic        hs;
    logic        vs;
    logic [13:0] ra;
    logic [16:0] roa;
    logic        chk_rom;
    string       ptag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int hc = 0, vc = 0, fr = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h hc=%0d vc=%0d fr=%0d", tag, act, exp, hc, vc, fr);
    end
  endtask

  task automatic push_expected();
    exp_t e;
    int col, row, dc, p, scan;
    logic [13:0] base;
    logic [7:0] code, attr, colr, glyph;
    logic blink, on, gbit;
    logic [3:0] idx, bgi;
    if (!rst_n) begin
      e.pix = 0; e.hs = 1; e.vs = 1; e.ra = 0; e.roa = 0; e.chk_rom = 1; e.ptag = "R12";
      q.push_back(e);
      return;
    end
    col  = hc / 16;
    row  = (vc >> 4) & 31;
    scan = vc & 15;
    e.hs = !(col >= 84 && col < 96);
    e.vs = !(vc >= VV + VFP && vc < VV + VFP + VS);
    e.ra = {((hc % 16) < 4) ? 2'd0 : ((hc % 16) < 8) ? 2'd1 : 2'd2, 5'(row), 7'(col)};
    base = {2'd0, 5'(row), 7'(col)};
    code = ram_fn(base);
    attr = ram_fn(base | 14'h1000);
    e.roa = {attr[7:3], code, 4'(scan)};
    e.chk_rom = (hc % 16) >= 8;
    if (!(col >= 2 && col < 82 && vc < VV)) begin
      e.pix = 0; e.ptag = "R4";
    end else begin
      dc = col - 2;
      p  = (hc % 16) / 2;
      base = {2'd0, 5'(row), 7'(dc)};
      code = ram_fn(base);
      attr = ram_fn(base | 14'h1000);
      colr = ram_fn(base | 14'h2000);
      glyph = rom_fn({attr[7:3], code, 4'(scan)});
      blink = ((fr >> BB) & 1) != 0;
      gbit = glyph[7 - p];
      on = (gbit || (attr[2] && scan == 15 - int'(ul_sel))) && !(blink && attr[0]);
      bgi = (blink && attr[1]) ? 4'd0 : colr[3:0];
      idx = on ? colr[7:4] : bgi;
      e.pix = pal(idx);
      if (blink && (attr[0] || attr[1])) e.ptag = "R11";
      else if (attr[2] && scan == 15 - int'(ul_sel)) e.ptag = "R10";
      else if (idx == 4'd6 || idx[3]) e.ptag = "R9";
      else if (on) e.ptag = "R7";
      else e.ptag = "R8";
    end
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (hc == HT - 1) begin
        hc = 0;
        if (vc == VT - 1) begin vc = 0; fr = fr + 1; end
        else vc = vc + 1;
      end else begin
        hc = hc + 1;
      end
    end
    push_expected();
  end

  int last_hs = -1, last_vs = -1;
  logic prev_hs = 1, prev_vs = 1;

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (!done && q.size() > 0) begin
      e = q.pop_front();
      check(e.ptag, 32'(pix_out), 32'(e.pix));
      check((e.ptag == "R12") ? "R12" : "R2", 32'(hsync_n), 32'(e.hs));
      check((e.ptag == "R12") ? "R12" : "R3", 32'(vsync_n), 32'(e.vs));
      check((e.ptag == "R12") ? "R12" : "R5", 32'(ram_addr), 32'(e.ra));
      if (e.chk_rom) check((e.ptag == "R12") ? "R12" : "R6", 32'(rom_addr), 32'(e.roa));
      if (rst_n && prev_hs && !hsync_n) begin
        if (last_hs >= 0) check("R1", 32'(cyc - last_hs), 32'(HT));
        last_hs = cyc;
      end
      if (rst_n && prev_vs && !vsync_n) begin
        if (last_vs >= 0) check("R1", 32'(cyc - last_vs), 32'(HT * VT));
        last_vs = cyc;
      end
      prev_hs = hsync_n;
      prev_vs = vsync_n;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int k = 1; k < 4; k++) begin
      do @(negedge clk); while (!(fr == k - 1 && vc == VV));
      ul_sel = 2'(k);
    end
    do @(negedge clk); while (fr < 4);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule